// File: doc/BRIEF.md
# NAND Flash Target Command Front-End

This block is the device side of a byte-wide NAND flash bus. It watches command-latch and address-latch strobes qualified by a write strobe. It decodes opcodes and collects address bytes, and it serves data, status or identification bytes on each read strobe. A 528-byte page register sits behind it. Bytes 512 to 527 of that register are the spare area. A host-side fill port loads the page register, which stands in for the cell array.

A read does not take a full column address. The opcode picks one of three areas: the low half of the page, the high half, or the spare bytes. The first address byte is then an offset within that area, and the next three bytes give the row. Once the last address byte is in, the block pulses a load request to the array with the row and holds its ready output low for a fixed number of clock cycles. A reset opcode cancels the busy period at once. Opcodes the block does not know are dropped without effect.

All bus strobes are single-cycle synchronous pulses sampled on the rising clock edge. The read strobe consumes the byte currently shown on the output, so the next byte appears after that edge.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset, readyOut is 1, the block is in read mode with the low-half area selected and column 0, so ioOut shows page byte 0.
- R2: Opcode 00h followed by four address cycles sets the column to the first address byte (low-half area, column 0..255). The other three bytes are the row, with the first one in row bits 7:0.
- R3: Opcode 01h followed by four address cycles sets the column to 256 plus the first address byte.
- R4: Opcode 50h followed by four address cycles sets the column to 512 plus bits 3:0 of the first address byte.
- R5: In read mode while ready, each read strobe advances the column by one. Column 527 wraps to 0 and the row is unchanged.
- R6: The edge that takes the fourth read address byte makes readyOut 0 for exactly BUSY_CYCLES cycles. In the first of those cycles arrLoadReq is 1 for one cycle, and arrRow holds the row.
- R7: Opcode 70h is accepted even while busy. Afterwards ioOut is the status byte: bit 7 = 1, bit 6 = readyOut, bits 5..0 = 0. So it reads 80h while busy and C0h while ready.
- R8: While ready, opcode 90h followed by an address cycle of 00h makes ioOut ECh. Each read strobe after that gives 76h.
- R9: Opcode FFh makes readyOut 1 on the next cycle, even while busy. It also selects read mode, the low-half area and column 0.
- R10: An opcode other than 00h, 01h, 50h, 70h, 90h and FFh leaves the mode, area and column unchanged.
- R11: While busy, opcodes other than 70h and FFh, address cycles and read strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cleIn | input | 1 | Command-latch qualifier |
| aleIn | input | 1 | Address-latch qualifier |
| weStrobe | input | 1 | One-cycle write strobe that latches ioIn |
| ioIn | input | 8 | Command, address byte |
| reStrobe | input | 1 | One-cycle read strobe, consumes the shown byte |
| ioOut | output | 8 | Page, status or identification byte |
| readyOut | output | 1 | 1 when ready, 0 while an array load is timed |
| arrLoadReq | output | 1 | One-cycle array load request |
| arrRow | output | 24 | Row latched from the address cycles |
| fillEn | input | 1 | Page register write enable |
| fillCol | input | 10 | Page register write column |
| fillData | input | 8 | Page register write data |

## Verification
A wrong column pointer shows up on ioOut in the very cycle after the edge that set it. The fault can come from a bad area base, a lost offset mask or a missed wrap. The model compares ioOut on every clock, so it is caught at the first strobe past the fault. A busy counter that is off by one moves the rising edge of readyOut by a cycle, and the bench measures the low window directly. Mode errors change the kind of byte on ioOut at once. Examples are an unknown opcode taken as a mode change, or a command accepted during busy. Such an error is seen one cycle after the opcode.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_ID     = 2'd2
  } modeT;

  typedef enum logic [1:0] {
    AREA_LOW   = 2'd0,
    AREA_HIGH  = 2'd1,
    AREA_SPARE = 2'd2
  } areaT;

  localparam logic [7:0] OP_RD_LOW   = 8'h00;
  localparam logic [7:0] OP_RD_HIGH  = 8'h01;
  localparam logic [7:0] OP_RD_SPARE = 8'h50;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_ABORT    = 8'hFF;

  typedef struct packed {
    logic       colLoad;
    logic       colInc;
    logic       colClear;
    logic       rowLoad;
    logic [3:0] rowSel;
  } ctrlStrobeT;

endpackage

// File: rtl/nand_front_ctrl.sv
module nand_front_ctrl
  import nand_front_pkg::*;
#(
  parameter int ROW_BYTES   = 3,
  parameter int BUSY_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cleIn,
  input  logic       aleIn,
  input  logic       weStrobe,
  input  logic [7:0] ioIn,
  input  logic       reStrobe,
  output modeT       modeQ,
  output areaT       areaQ,
  output logic       idSecondQ,
  output logic       readyOut,
  output logic       loadReqQ,
  output ctrlStrobeT strobe
);
  localparam int ADDR_CYC = ROW_BYTES + 1;
  localparam int AW = $clog2(ADDR_CYC + 1);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [AW-1:0] addrLeftQ, addrLeftD, addrIdx;
  logic [BW-1:0] busyQ, busyD;
  modeT modeD;
  areaT areaD;
  logic idSecondD, startBusy, abort, busy, cmdWr, addrWr;

  assign busy     = (busyQ != '0);
  assign readyOut = ~busy;
  assign cmdWr    = weStrobe & cleIn;
  assign addrWr   = weStrobe & aleIn & ~cleIn;
  assign addrIdx  = AW'(ADDR_CYC) - addrLeftQ;

  always_comb begin
    modeD     = modeQ;
    areaD     = areaQ;
    idSecondD = idSecondQ;
    addrLeftD = addrLeftQ;
    startBusy = 1'b0;
    abort     = 1'b0;
    strobe    = '0;
    if (cmdWr) begin
      if (ioIn == OP_ABORT) begin
        abort           = 1'b1;
        modeD           = MODE_READ;
        areaD           = AREA_LOW;
        idSecondD       = 1'b0;
        addrLeftD       = '0;
        strobe.colClear = 1'b1;
      end else if (ioIn == OP_STATUS) begin
        modeD     = MODE_STATUS;
        addrLeftD = '0;
      end else if (!busy) begin
        unique case (ioIn)
          OP_RD_LOW:   begin modeD = MODE_READ; areaD = AREA_LOW;   addrLeftD = AW'(ADDR_CYC); end
          OP_RD_HIGH:  begin modeD = MODE_READ; areaD = AREA_HIGH;  addrLeftD = AW'(ADDR_CYC); end
          OP_RD_SPARE: begin modeD = MODE_READ; areaD = AREA_SPARE; addrLeftD = AW'(ADDR_CYC); end
          OP_IDENT:    begin modeD = MODE_ID; idSecondD = 1'b0; addrLeftD = AW'(1); end
          default: ;
        endcase
      end
    end else if (addrWr && addrLeftQ != '0 && !busy) begin
      if (modeQ == MODE_READ) begin
        if (addrIdx == '0) strobe.colLoad = 1'b1;
        else begin
          strobe.rowLoad = 1'b1;
          strobe.rowSel  = 4'(addrIdx - AW'(1));
        end
        addrLeftD = addrLeftQ - AW'(1);
        startBusy = (addrLeftQ == AW'(1));
      end else begin
        idSecondD = 1'b0;
        addrLeftD = '0;
      end
    end else if (reStrobe && !busy) begin
      if (modeQ == MODE_READ) strobe.colInc = 1'b1;
      else if (modeQ == MODE_ID) idSecondD = 1'b1;
    end

    if (abort)          busyD = '0;
    else if (startBusy) busyD = BW'(BUSY_CYCLES);
    else if (busy)      busyD = busyQ - BW'(1);
    else                busyD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_READ;
      areaQ     <= AREA_LOW;
      idSecondQ <= 1'b0;
      addrLeftQ <= '0;
      busyQ     <= '0;
      loadReqQ  <= 1'b0;
    end else begin
      modeQ     <= modeD;
      areaQ     <= areaD;
      idSecondQ <= idSecondD;
      addrLeftQ <= addrLeftD;
      busyQ     <= busyD;
      loadReqQ  <= startBusy;
    end
  end
endmodule

// File: rtl/nand_front_dp.sv
module nand_front_dp
  import nand_front_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_BYTES   = 3,
  parameter logic [7:0] ID_MAKER  = 8'hEC,
  parameter logic [7:0] ID_DEVICE = 8'h76,
  localparam int COL_W   = $clog2(PAGE_BYTES),
  localparam int ROW_W   = 8 * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       ioIn,
  input  ctrlStrobeT       strobe,
  input  modeT             modeQ,
  input  areaT             areaQ,
  input  logic             idSecondQ,
  input  logic             readyOut,
  input  logic             fillEn,
  input  logic [COL_W-1:0] fillCol,
  input  logic [7:0]       fillData,
  output logic [7:0]       ioOut,
  output logic [ROW_W-1:0] arrRow
);
  localparam int SPARE_W = $clog2(SPARE_BYTES);

  logic [7:0]       pageMem [PAGE_BYTES];
  logic [COL_W-1:0] colQ, colStart;

  always_comb begin
    case (areaQ)
      AREA_HIGH:  colStart = COL_W'(HALF_BYTES) + COL_W'(ioIn);
      AREA_SPARE: colStart = COL_W'(2 * HALF_BYTES) + COL_W'(ioIn[SPARE_W-1:0]);
      default:    colStart = COL_W'(ioIn);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) colQ <= '0;
    else if (strobe.colClear) colQ <= '0;
    else if (strobe.colLoad) colQ <= colStart;
    else if (strobe.colInc)
      colQ <= (colQ == COL_W'(PAGE_BYTES - 1)) ? '0 : colQ + COL_W'(1);
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_rowByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) arrRow[g*8 +: 8] <= '0;
      else if (strobe.rowLoad && strobe.rowSel == 4'(g)) arrRow[g*8 +: 8] <= ioIn;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn && fillCol < COL_W'(PAGE_BYTES)) pageMem[fillCol] <= fillData;
  end

  always_comb begin
    case (modeQ)
      MODE_STATUS: ioOut = {1'b1, readyOut, 6'b0};
      MODE_ID:     ioOut = idSecondQ ? ID_DEVICE : ID_MAKER;
      default:     ioOut = pageMem[colQ];
    endcase
  end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_front_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_BYTES   = 3,
  parameter int BUSY_CYCLES = 20,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int ROW_W = 8 * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cleIn,
  input  logic             aleIn,
  input  logic             weStrobe,
  input  logic [7:0]       ioIn,
  input  logic             reStrobe,
  output logic [7:0]       ioOut,
  output logic             readyOut,
  output logic             arrLoadReq,
  output logic [ROW_W-1:0] arrRow,
  input  logic             fillEn,
  input  logic [COL_W-1:0] fillCol,
  input  logic [7:0]       fillData
);
  modeT       modeQ;
  areaT       areaQ;
  logic       idSecondQ;
  ctrlStrobeT strobe;

  nand_front_ctrl #(.ROW_BYTES(ROW_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cleIn(cleIn), .aleIn(aleIn), .weStrobe(weStrobe),
    .ioIn(ioIn), .reStrobe(reStrobe), .modeQ(modeQ), .areaQ(areaQ),
    .idSecondQ(idSecondQ), .readyOut(readyOut), .loadReqQ(arrLoadReq), .strobe(strobe)
  );

  nand_front_dp #(
    .PAGE_BYTES(PAGE_BYTES), .HALF_BYTES(HALF_BYTES),
    .SPARE_BYTES(SPARE_BYTES), .ROW_BYTES(ROW_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .strobe(strobe), .modeQ(modeQ),
    .areaQ(areaQ), .idSecondQ(idSecondQ), .readyOut(readyOut),
    .fillEn(fillEn), .fillCol(fillCol), .fillData(fillData),
    .ioOut(ioOut), .arrRow(arrRow)
  );
endmodule

// File: rtl/nand_front_chk.sv
module nand_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cleIn,
  input logic       aleIn,
  input logic       weStrobe,
  input logic [7:0] ioIn,
  input logic [7:0] ioOut,
  input logic       readyOut,
  input logic       arrLoadReq
);
  AST_BUSY_FROM_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |-> $past(weStrobe && aleIn)); // R6
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    arrLoadReq |=> !arrLoadReq); // R6
  AST_LOAD_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    arrLoadReq |-> !readyOut); // R6
  AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (weStrobe && cleIn && ioIn == 8'h70) |=> (ioOut == {1'b1, readyOut, 6'b0})); // R7
  AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && weStrobe && cleIn && ioIn == 8'h90) |=> (ioOut == 8'hEC)); // R8
  AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (weStrobe && cleIn && ioIn == 8'hFF) |=> readyOut); // R9
endmodule

bind nand_cmd_front nand_front_chk chk_i (
  .clk(clk), .rstN(rstN), .cleIn(cleIn), .aleIn(aleIn), .weStrobe(weStrobe),
  .ioIn(ioIn), .ioOut(ioOut), .readyOut(readyOut), .arrLoadReq(arrLoadReq)
);

// File: tb/nand_cmd_front_tb_top.sv
module nand_cmd_front_tb_top;
  localparam int BUSY = 12;
  localparam int PAGE = 528;

  logic clk = 1'b0, rstN = 1'b0;
  logic cleIn = 0, aleIn = 0, weStrobe = 0, reStrobe = 0, fillEn = 0;
  logic [7:0] ioIn = 0, fillData = 0;
  logic [9:0] fillCol = 0;
  logic [7:0] ioOut;
  logic readyOut, arrLoadReq;
  logic [23:0] arrRow;

  int total = 0, bad = 0;
  bit cmpOn = 0;
  string curReq = "R1";
  logic [7:0] refPage [PAGE];

  // reference model state
  int mMode, mArea, mCol, mBusy, mIdx, mLeft;
  bit mLoad;
  logic [7:0] mRow [3];

  always #4 clk = ~clk;

  nand_cmd_front #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .cleIn(cleIn), .aleIn(aleIn), .weStrobe(weStrobe),
    .ioIn(ioIn), .reStrobe(reStrobe), .ioOut(ioOut), .readyOut(readyOut),
    .arrLoadReq(arrLoadReq), .arrRow(arrRow), .fillEn(fillEn),
    .fillCol(fillCol), .fillData(fillData)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mArea = 0; mCol = 0; mBusy = 0; mIdx = 0; mLeft = 0; mLoad = 0;
      for (int k = 0; k < 3; k++) mRow[k] = 0;
    end else begin
      bit wasBusy, started, aborted;
      wasBusy = (mBusy != 0); started = 0; aborted = 0;
      mLoad = 0;
      if (weStrobe && cleIn) begin
        if (ioIn == 8'hFF) begin
          aborted = 1; mMode = 0; mArea = 0; mCol = 0; mIdx = 0; mLeft = 0; mBusy = 0;
        end else if (ioIn == 8'h70) begin
          mMode = 1; mLeft = 0;
        end else if (!wasBusy) begin
          if (ioIn == 8'h00) begin mMode = 0; mArea = 0; mLeft = 4; end
          else if (ioIn == 8'h01) begin mMode = 0; mArea = 1; mLeft = 4; end
          else if (ioIn == 8'h50) begin mMode = 0; mArea = 2; mLeft = 4; end
          else if (ioIn == 8'h90) begin mMode = 2; mIdx = 0; mLeft = 1; end
        end
      end else if (weStrobe && aleIn && mLeft > 0 && !wasBusy) begin
        if (mMode == 0) begin
          int k;
          k = 4 - mLeft;
          if (k == 0) mCol = (mArea == 0) ? int'(ioIn) :
                             (mArea == 1) ? 256 + int'(ioIn) : 512 + int'(ioIn % 16);
          else mRow[k-1] = ioIn;
          mLeft--;
          if (mLeft == 0) begin started = 1; mLoad = 1; end
        end else begin
          mIdx = 0; mLeft = 0;
        end
      end else if (reStrobe && !wasBusy) begin
        if (mMode == 0) mCol = (mCol == PAGE - 1) ? 0 : mCol + 1;
        else if (mMode == 2) mIdx = 1;
      end
      if (started) mBusy = BUSY;
      else if (!aborted && wasBusy) mBusy--;
    end
    #2;
    if (cmpOn) begin
      logic [7:0] expIo;
      expIo = (mMode == 1) ? {1'b1, (mBusy == 0), 6'b0} :
              (mMode == 2) ? (mIdx ? 8'h76 : 8'hEC) : refPage[mCol];
      chk(ioOut === expIo, curReq, ioOut, expIo);
      chk(readyOut === (mBusy == 0), {curReq, "/R6 ready"}, readyOut, mBusy == 0);
      chk(arrLoadReq === mLoad, "R6 load pulse", arrLoadReq, mLoad);
      chk(arrRow === {mRow[2], mRow[1], mRow[0]}, "R6 row", arrRow, {mRow[2], mRow[1], mRow[0]});
    end
  end

  task automatic sendCmd(logic [7:0] b);
    @(negedge clk); cleIn = 1; weStrobe = 1; ioIn = b;
    @(negedge clk); cleIn = 0; weStrobe = 0;
  endtask

  task automatic sendAddr(logic [7:0] b);
    @(negedge clk); aleIn = 1; weStrobe = 1; ioIn = b;
    @(negedge clk); aleIn = 0; weStrobe = 0;
  endtask

  task automatic readStb();
    @(negedge clk); reStrobe = 1;
    @(negedge clk); reStrobe = 0;
  endtask

  task automatic sendRead(logic [7:0] op, logic [7:0] off, logic [7:0] r0, logic [7:0] r1, logic [7:0] r2);
    sendCmd(op); sendAddr(off); sendAddr(r0); sendAddr(r1); sendAddr(r2);
  endtask

  task automatic waitReady();
    while (!readyOut) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lowCnt;
    for (int i = 0; i < PAGE; i++) begin
      refPage[i] = pat(i);
      @(negedge clk); fillEn = 1; fillCol = 10'(i); fillData = pat(i);
    end
    @(negedge clk); fillEn = 0;
    rstN = 1;
    cmpOn = 1;
    @(negedge clk);
    curReq = "R1";
    chk(readyOut === 1'b1, "R1 ready", readyOut, 1);
    chk(ioOut === pat(0), "R1 byte0", ioOut, pat(0));

    curReq = "R2";
    sendRead(8'h00, 8'd5, 8'h11, 8'h22, 8'h33);
    chk(arrLoadReq === 1'b1, "R6 pulse", arrLoadReq, 1);
    chk(arrRow === 24'h332211, "R2 row", arrRow, 24'h332211);
    lowCnt = 0;
    while (!readyOut) begin lowCnt++; @(negedge clk); end
    chk(lowCnt == BUSY, "R6 busy length", lowCnt, BUSY);
    chk(ioOut === pat(5), "R2 column", ioOut, pat(5));
    curReq = "R5";
    readStb(); readStb(); readStb();
    chk(ioOut === pat(8), "R5 increment", ioOut, pat(8));

    curReq = "R3";
    sendRead(8'h01, 8'd10, 8'h01, 8'h02, 8'h03);
    waitReady();
    chk(ioOut === pat(266), "R3 column", ioOut, pat(266));

    curReq = "R4";
    sendRead(8'h50, 8'h1C, 8'h04, 8'h05, 8'h06);
    waitReady();
    chk(ioOut === pat(524), "R4 spare column", ioOut, pat(524));
    curReq = "R5";
    for (int i = 0; i < 4; i++) readStb();
    chk(ioOut === pat(0), "R5 wrap", ioOut, pat(0));
    chk(arrRow === 24'h060504, "R5 row kept", arrRow, 24'h060504);
    readStb();
    chk(ioOut === pat(1), "R5 after wrap", ioOut, pat(1));

    curReq = "R7";
    sendRead(8'h00, 8'd7, 8'h07, 8'h08, 8'h09);
    sendCmd(8'h70);
    chk(ioOut === 8'h80, "R7 busy status", ioOut, 8'h80);
    waitReady();
    chk(ioOut === 8'hC0, "R7 ready status", ioOut, 8'hC0);

    curReq = "R11";
    sendRead(8'h00, 8'd9, 8'h0A, 8'h0B, 8'h0C);
    sendCmd(8'h90);
    readStb();
    sendAddr(8'h40);
    waitReady();
    chk(ioOut === pat(9), "R11 ignored while busy", ioOut, pat(9));

    curReq = "R10";
    readStb();
    chk(ioOut === pat(10), "R10 before", ioOut, pat(10));
    sendCmd(8'h3C);
    chk(ioOut === pat(10), "R10 unknown opcode", ioOut, pat(10));
    readStb();
    chk(ioOut === pat(11), "R10 still read mode", ioOut, pat(11));

    curReq = "R8";
    sendCmd(8'h90); sendAddr(8'h00);
    chk(ioOut === 8'hEC, "R8 first id", ioOut, 8'hEC);
    readStb();
    chk(ioOut === 8'h76, "R8 second id", ioOut, 8'h76);
    readStb();
    chk(ioOut === 8'h76, "R8 held id", ioOut, 8'h76);

    curReq = "R9";
    sendRead(8'h01, 8'd3, 8'h0D, 8'h0E, 8'h0F);
    @(negedge clk);
    sendCmd(8'hFF);
    chk(readyOut === 1'b1, "R9 abort ready", readyOut, 1);
    chk(ioOut === pat(0), "R9 column cleared", ioOut, pat(0));
    repeat (BUSY + 2) @(negedge clk);
    chk(readyOut === 1'b1, "R9 stays ready", readyOut, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule